// File: doc/BRIEF.md
# Byte-Window Program RAM Loader

This block lets a host fill and inspect a 512-word program store of 32-bit instructions through a narrow, byte-wide register port. The host first places a word address in two address registers: a low byte and a high register of which only bit 0 is kept. It then moves bytes through a single data window register. Each window access handles one byte lane of the addressed word, least significant lane first. After the fourth lane the word address steps to the next word, and the lane pointer returns to lane 0.

Window traffic is accepted only while the load-enable bit of the control register is set. The same register carries a sequencer reset bit, which drives an output to the sequencer core. Written bytes are held in a staging buffer, and the whole word goes into the store in a single write when the top byte arrives. The sequencer fetches instructions through its own read port. That port has one cycle of latency and is independent of the host window.

Top module: `progRamLoader`

## Requirements
- R1: After reset, the control register, the word address and the lane pointer are zero, `seqReset` is low and `seqRdData` is zero.
- R2: `hostSel` picks the register: 0 is control, 1 is the data window, 2 is the address low byte, 3 is the address high register. The address high register keeps only bit 0 of a write and reads back as `{7'b0, addr[8]}`. Reads of control return `{6'b0, seqReset, loadEnable}`.
- R3: Control bit 0 is the load enable and control bit 1 is the sequencer reset. `seqReset` equals bit 1 of the last control write from the clock edge that takes the write.
- R4: With load enabled, four window writes fill lanes 0, 1, 2 and 3 (bits 7:0, 15:8, 23:16, 31:24). The word is written to the store at the current address on the fourth write.
- R5: The word address increases by one only on a window access at lane 3. Accesses at lanes 0 to 2 leave it unchanged.
- R6: The word address wraps from 511 to 0.
- R7: A write to either address register returns the lane pointer to 0. The next window access therefore uses lane 0.
- R8: Window writes while load enable is clear have no effect on the store, the lane pointer or the address.
- R9: With load enabled, a window read returns the current lane of the word at the current address and steps the lane pointer and address exactly as a write does. With load enable clear, a window read returns 0 and steps nothing.
- R10: The sequencer port returns `mem[seqRdAddr]` one cycle after the address is presented. If a host commit to the same word happens in that cycle, the port returns the word as it was before the commit.
- R11: When `hostWrEn` and `hostRdEn` are both high on the window, the write is performed and the lane pointer and address step only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe (has side effects on the window) |
| hostSel | input | 2 | Register select |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte (combinational) |
| seqRdAddr | input | 9 | Sequencer fetch address |
| seqRdData | output | 32 | Sequencer fetched word, one cycle later |
| seqReset | output | 1 | Sequencer reset from control bit 1 |

## Verification
Two things can land in the same cycle: the sequencer fetch and a host commit of the fourth byte to the same word. The bench provokes this by holding `seqRdAddr` on the word being completed while the top byte is written. It expects the old contents in the cycle that follows and the new word one cycle later. The bench also raises both host strobes together on the window. It checks that the write wins and that the address and lane move by only a single step.

// File: rtl/prl_pkg.sv
package prl_pkg;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = BYTE_W * WORD_BYTES;
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES);
  localparam int unsigned CTRL_W     = 2;
  localparam int unsigned CTRL_LOAD  = 0;
  localparam int unsigned CTRL_SRST  = 1;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_WINDOW  = 2'd1,
    SEL_ADDR_LO = 2'd2,
    SEL_ADDR_HI = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              stageEn;
    logic              commitEn;
    logic [LANE_W-1:0] lane;
  } laneStrobe_t;

endpackage

// File: rtl/progRamCtrl.sv
module progRamCtrl
  import prl_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hostWrEn,
  input  logic                hostRdEn,
  input  logic [1:0]          hostSel,
  input  logic [BYTE_W-1:0]   hostWrData,
  input  logic [WORD_W-1:0]   windowWord,
  output logic [BYTE_W-1:0]   hostRdData,
  output laneStrobe_t         strobe,
  output logic [ADDR_W-1:0]   wordAddr,
  output logic [LANE_W-1:0]   laneIdx,
  output logic                loadEn,
  output logic                seqReset
);

  localparam int unsigned HI_W = ADDR_W - BYTE_W;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

  regSel_e           selE;
  logic [CTRL_W-1:0] ctrlReg;
  logic              isWindow;
  logic              winWrite;
  logic              winRead;
  logic              winStep;
  logic              lastLane;
  logic              addrWrite;

  assign loadEn   = ctrlReg[CTRL_LOAD];
  assign seqReset = ctrlReg[CTRL_SRST];

  always_comb begin
    selE      = regSel_e'(hostSel);
    isWindow  = (selE == SEL_WINDOW);
    winWrite  = hostWrEn && isWindow && loadEn;
    winRead   = hostRdEn && !hostWrEn && isWindow && loadEn;
    winStep   = winWrite || winRead;
    lastLane  = (laneIdx == LAST_LANE);
    addrWrite = hostWrEn && ((selE == SEL_ADDR_LO) || (selE == SEL_ADDR_HI));
    strobe.stageEn  = winWrite;
    strobe.commitEn = winWrite && lastLane;
    strobe.lane     = laneIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
    end else if (hostWrEn && (selE == SEL_CTRL)) begin
      ctrlReg <= hostWrData[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordAddr <= '0;
      laneIdx  <= '0;
    end else if (addrWrite) begin
      laneIdx <= '0;
      if (selE == SEL_ADDR_LO) begin
        wordAddr[BYTE_W-1:0] <= hostWrData;
      end else begin
        wordAddr[ADDR_W-1:BYTE_W] <= hostWrData[HI_W-1:0];
      end
    end else if (winStep) begin
      laneIdx <= laneIdx + 1'b1;
      if (lastLane) begin
        wordAddr <= wordAddr + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (selE)
      SEL_CTRL:    hostRdData = BYTE_W'(ctrlReg);
      SEL_WINDOW:  hostRdData = loadEn ? windowWord[laneIdx*BYTE_W +: BYTE_W] : '0;
      SEL_ADDR_LO: hostRdData = wordAddr[BYTE_W-1:0];
      SEL_ADDR_HI: hostRdData = BYTE_W'(wordAddr[ADDR_W-1:BYTE_W]);
      default:     hostRdData = '0;
    endcase
  end

endmodule

// File: rtl/progRamData.sv
module progRamData
  import prl_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  laneStrobe_t       strobe,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [ADDR_W-1:0] seqRdAddr,
  output logic [WORD_W-1:0] windowWord,
  output logic [WORD_W-1:0] seqRdData
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] wordNext;

  genvar g;
  generate
    for (g = 0; g < WORD_BYTES; g++) begin : gLane
      if (g == WORD_BYTES - 1) begin : gTop
        assign wordNext[g*BYTE_W +: BYTE_W] = hostWrData;
      end else begin : gStage
        logic [BYTE_W-1:0] stageQ;
        always_ff @(posedge clk) begin
          if (rst) begin
            stageQ <= '0;
          end else if (strobe.stageEn && (strobe.lane == LANE_W'(g))) begin
            stageQ <= hostWrData;
          end
        end
        assign wordNext[g*BYTE_W +: BYTE_W] = stageQ;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.commitEn) begin
      store[wordAddr] <= wordNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seqRdData <= '0;
    end else begin
      seqRdData <= store[seqRdAddr];
    end
  end

  assign windowWord = store[wordAddr];

endmodule

// File: rtl/progRamLoader.sv
module progRamLoader
  import prl_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [1:0]        hostSel,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  input  logic [ADDR_W-1:0] seqRdAddr,
  output logic [31:0]       seqRdData,
  output logic              seqReset
);

  laneStrobe_t       strobe;
  logic [ADDR_W-1:0] wordAddr;
  logic [LANE_W-1:0] laneIdx;
  logic              loadEn;
  logic [WORD_W-1:0] windowWord;

  progRamCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .hostSel    (hostSel),
    .hostWrData (hostWrData),
    .windowWord (windowWord),
    .hostRdData (hostRdData),
    .strobe     (strobe),
    .wordAddr   (wordAddr),
    .laneIdx    (laneIdx),
    .loadEn     (loadEn),
    .seqReset   (seqReset)
  );

  progRamData #(.ADDR_W(ADDR_W)) u_data (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .hostWrData (hostWrData),
    .wordAddr   (wordAddr),
    .seqRdAddr  (seqRdAddr),
    .windowWord (windowWord),
    .seqRdData  (seqRdData)
  );

endmodule

// File: rtl/progRamLoader_chk.sv
module progRamLoader_chk
  import prl_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic [1:0]        hostSel,
  input logic [7:0]        hostWrData,
  input logic              seqReset,
  input logic [ADDR_W-1:0] wordAddr,
  input logic [LANE_W-1:0] laneIdx,
  input logic              loadEn
);

  logic winAccess;
  assign winAccess = (hostWrEn || hostRdEn) && (hostSel == 2'd1) && loadEn;

  AST_SEQRST_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (hostWrEn && hostSel == 2'd0) |=> (seqReset == $past(hostWrData[1]))); // R3

  AST_ADDR_WRITE_LANE0: assert property (@(posedge clk) disable iff (rst)
    (hostWrEn && hostSel[1]) |=> (laneIdx == '0)); // R7

  AST_DISABLED_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (hostWrEn && hostSel == 2'd1 && !loadEn) |=> ($stable(wordAddr) && $stable(laneIdx))); // R8

  AST_ADDR_STEP_LAST: assert property (@(posedge clk) disable iff (rst)
    (winAccess && laneIdx == LANE_W'(WORD_BYTES-1)) |=> (wordAddr == $past(wordAddr) + 1'b1)); // R6

  AST_ADDR_HOLD_EARLY: assert property (@(posedge clk) disable iff (rst)
    (winAccess && laneIdx != LANE_W'(WORD_BYTES-1)) |=> $stable(wordAddr)); // R5

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (winAccess && hostWrEn && hostRdEn) |=> (laneIdx == $past(laneIdx) + 1'b1)); // R11

endmodule

bind progRamLoader progRamLoader_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/progRamLoader_bench.sv
`timescale 1ns/1ps
module progRamLoader_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hostWrEn = 1'b0;
  logic       hostRdEn = 1'b0;
  logic [1:0] hostSel = 2'd0;
  logic [7:0] hostWrData = 8'd0;
  logic [7:0] hostRdData;
  logic [8:0] seqRdAddr = 9'd0;
  logic [31:0] seqRdData;
  logic       seqReset;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] refMem [int];
  int          refAddr = 0;
  int          refLane = 0;
  logic [7:0]  refStage [3];
  logic [1:0]  refCtrl = 2'b00;

  always #5 clk = ~clk;

  progRamLoader u_progRamLoader (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostSel(hostSel), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .seqRdAddr(seqRdAddr), .seqRdData(seqRdData), .seqReset(seqReset)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit refRead(input logic [1:0] sel, output logic [7:0] v);
    v = 8'h00;
    case (sel)
      2'd0: v = {6'b0, refCtrl};
      2'd2: v = refAddr[7:0];
      2'd3: v = {7'b0, refAddr[8]};
      default: begin
        if (!refCtrl[0]) v = 8'h00;
        else if (refMem.exists(refAddr)) v = refMem[refAddr][refLane*8 +: 8];
        else return 1'b0;
      end
    endcase
    return 1'b1;
  endfunction

  task automatic advance();
    if (refLane == 3) begin
      refLane = 0;
      refAddr = (refAddr + 1) % 512;
    end else begin
      refLane++;
    end
  endtask

  // one clock: drive after the falling edge, compare read data, model the edge, compare registered outputs
  task automatic step(input bit wr, input bit rd, input logic [1:0] sel,
                      input logic [7:0] d, input logic [8:0] sa, input string tag);
    logic [7:0]  expRd;
    bit          rdKnown;
    bit          seqKnown;
    logic [31:0] expSeq;
    hostWrEn = wr; hostRdEn = rd; hostSel = sel; hostWrData = d; seqRdAddr = sa;
    #1;
    rdKnown = refRead(sel, expRd);
    if (rdKnown) chk(hostRdData === expRd, tag, 32'(hostRdData), 32'(expRd));
    @(posedge clk);
    seqKnown = refMem.exists(int'(sa));
    expSeq = seqKnown ? refMem[int'(sa)] : 32'h0;
    if (wr) begin
      case (sel)
        2'd0: refCtrl = d[1:0];
        2'd2: begin refAddr = (refAddr & 32'h100) | int'(d); refLane = 0; end
        2'd3: begin refAddr = (refAddr & 32'hFF) | (int'(d[0]) << 8); refLane = 0; end
        default: if (refCtrl[0]) begin
          if (refLane < 3) refStage[refLane] = d;
          else refMem[refAddr] = {d, refStage[2], refStage[1], refStage[0]};
          advance();
        end
      endcase
    end else if (rd && sel == 2'd1 && refCtrl[0]) begin
      advance();
    end
    @(negedge clk);
    if (seqKnown) chk(seqRdData === expSeq, tag, seqRdData, expSeq);
    chk(seqReset === refCtrl[1], tag, 32'(seqReset), 32'(refCtrl[1]));
    hostWrEn = 0; hostRdEn = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, sel, d, 9'd0, tag);
  endtask

  task automatic rd(input logic [1:0] sel, input string tag);
    step(1'b0, 1'b1, sel, 8'h00, 9'd0, tag);
  endtask

  task automatic wrWord(input logic [31:0] w, input string tag);
    for (int i = 0; i < 4; i++) wr(2'd1, w[i*8 +: 8], tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(seqReset === 1'b0, "R1", 32'(seqReset), 0);
    chk(seqRdData === 32'h0, "R1", seqRdData, 0);
    step(0, 0, 2'd0, 0, 0, "R1");
    step(0, 0, 2'd2, 0, 0, "R1");
    step(0, 0, 2'd3, 0, 0, "R1");
    // R3 load enable, R2 readback
    wr(2'd0, 8'hFD, "R3");
    step(0, 0, 2'd0, 0, 0, "R2");
    // R4 word assembly, R5 stepping
    wr(2'd2, 8'h10, "R2");
    wr(2'd3, 8'h00, "R2");
    wrWord(32'h44332211, "R4");
    step(0, 0, 2'd2, 0, 9'h010, "R4");
    step(0, 0, 2'd2, 0, 9'h010, "R5");
    wr(2'd1, 8'hAA, "R5");
    wr(2'd1, 8'hBB, "R5");
    step(0, 0, 2'd2, 0, 9'h010, "R5");
    // R7 address write restarts the lane pointer
    wr(2'd2, 8'h20, "R7");
    wrWord(32'hDEADBEEF, "R7");
    step(0, 0, 2'd2, 0, 9'h020, "R7");
    // R8 disabled writes ignored
    wr(2'd0, 8'h00, "R8");
    wr(2'd2, 8'h20, "R8");
    wr(2'd0, 8'h01, "R8");
    wr(2'd0, 8'h00, "R8");
    wr(2'd1, 8'h55, "R8");
    wr(2'd1, 8'h66, "R8");
    step(0, 0, 2'd2, 0, 9'h020, "R8");
    wr(2'd0, 8'h01, "R8");
    rd(2'd1, "R8");
    // R2 high register keeps bit 0, R6 wrap
    wr(2'd3, 8'hFF, "R2");
    step(0, 0, 2'd3, 0, 0, "R2");
    wr(2'd2, 8'hFF, "R6");
    wrWord(32'hCAFE0001, "R6");
    step(0, 0, 2'd2, 0, 9'h1FF, "R6");
    step(0, 0, 2'd3, 0, 9'h1FF, "R6");
    // R9 window reads
    wr(2'd3, 8'h00, "R9");
    wr(2'd2, 8'h10, "R9");
    for (int i = 0; i < 4; i++) rd(2'd1, "R9");
    step(0, 0, 2'd2, 0, 0, "R9");
    wr(2'd2, 8'h10, "R9");
    rd(2'd1, "R9");
    wr(2'd0, 8'h00, "R9");
    rd(2'd1, "R9");
    rd(2'd1, "R9");
    wr(2'd0, 8'h01, "R9");
    rd(2'd1, "R9");
    step(0, 0, 2'd2, 0, 0, "R9");
    // R10 fetch of the word being committed in the same cycle
    wr(2'd2, 8'h30, "R10");
    wrWord(32'h01020304, "R10");
    wr(2'd2, 8'h30, "R10");
    for (int i = 0; i < 3; i++) wr(2'd1, 8'h70 + 8'(i), "R10");
    step(1, 0, 2'd1, 8'h7F, 9'h030, "R10");
    step(0, 0, 2'd0, 0, 9'h030, "R10");
    // R11 both strobes on the window
    wr(2'd2, 8'h40, "R11");
    step(1, 1, 2'd1, 8'h91, 0, "R11");
    step(1, 1, 2'd1, 8'h92, 0, "R11");
    step(1, 1, 2'd1, 8'h93, 0, "R11");
    step(1, 1, 2'd1, 8'h94, 9'h040, "R11");
    step(0, 0, 2'd2, 0, 9'h040, "R11");
    // R3 sequencer reset bit
    wr(2'd0, 8'h02, "R3");
    step(0, 0, 2'd0, 0, 0, "R3");
    wr(2'd0, 8'h01, "R3");
    finishRun();
  end

endmodule